// File: doc/BRIEF.md
# Command/Response FIFO Engine

This block is the byte-wide command and response path of a trusted-module host interface. The locality that owns the interface writes a command one byte at a time into a shared buffer through a data FIFO port. The engine reads the big-endian length field in the command header to find the end of the command. A go request then hands the command to a backend over a start/done handshake. The backend writes its response into the same buffer, and the host drains it through the same FIFO port.

A single pointer serves as the fill level while the command is written and as the read position while the response is drained. A status word reports the handshake flags and a burst count. The burst count is the number of response bytes still to be read, or the free buffer space when no response is pending. The host can rewind and re-read a response. It can also abort a command that is being received or executed, which brings the engine back to the ready state.

Top module: `cmdrsp_fifo_engine`

## Requirements
- R1: After reset the engine is idle. Status flags (bits 7:0) read 0, the burst count (bits 23:8) equals DEPTH, and a FIFO read returns the no-data byte 0xFF.
- R2: A status write is acted on only if the writer is the active owner and, after masking to bit 6 (command-ready), bit 5 (go) and bit 1 (retry), exactly one of those bits remains. Any other status write has no effect.
- R3: Command-ready in idle moves to ready, sets status bit 6, and pulses `evt_cmd_ready` for one cycle.
- R4: The first FIFO write in ready moves the engine to reception and sets expect (bit 3) and valid (bit 7). FIFO writes in idle, execution or completion are dropped.
- R5: Once more than 5 bytes are held, the command length is taken from header bytes 2..5, big-endian with byte 2 most significant. Expect stays set while that length exceeds the bytes received and clears when they are equal or more.
- R6: A write to a full buffer stores nothing, clears expect and leaves valid set. The pointer never exceeds DEPTH.
- R7: Go in reception with expect clear enters execution and pulses `be_start` once, with `be_len` equal to the bytes received. Go in any other case is ignored.
- R8: When `be_done` arrives in execution, the engine enters completion with valid and data-available (bit 4) set and the pointer at 0. If `be_selftest` is high, self-test-done (bit 2) is set.
- R9: In completion with data-available set, FIFO reads return the response bytes in order. The last byte clears data-available and leaves valid. Every other FIFO read returns 0xFF and moves nothing.
- R10: The burst count is the remaining response length (header length capped at DEPTH, minus pointer) while data-available is set, and DEPTH minus pointer otherwise. A byte-size status read caps it at 0xFF.
- R11: Retry in completion rewinds the pointer and restores valid plus data-available.
- R12: Command-ready in completion rewinds the pointer, moves to ready, clears data-available and sets command-ready with an event pulse. Command-ready in ready only rewinds the pointer.
- R13: Command-ready in reception aborts at once to ready with command-ready set and an event pulse. In execution it pulses `be_cancel`, and the next `be_done` lands in ready with command-ready set and an event, not in completion.
- R14: Every status update keeps the self-test-done bit, which clears only on reset. Bits 27:26 always show the FAMILY parameter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_fifo_sel | input | 1 | 1 selects the data FIFO, 0 selects the status word |
| host_active | input | 1 | Access comes from the active owner |
| host_byte_rd | input | 1 | Status read is one byte wide |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 32 | Read data, all ones for a non-owner |
| be_start | output | 1 | One-cycle start pulse to the backend |
| be_len | output | PW | Command length handed to the backend |
| be_cancel | output | 1 | One-cycle cancel pulse |
| be_raddr | input | AW | Backend buffer read address |
| be_rdata | output | 8 | Backend buffer read data |
| be_we | input | 1 | Backend response byte write |
| be_waddr | input | AW | Backend response write address |
| be_wdata | input | 8 | Backend response byte |
| be_done | input | 1 | Backend finished |
| be_selftest | input | 1 | Self-test completed, qualified by be_done |
| evt_cmd_ready | output | 1 | One-cycle command-ready event |

## Verification
The assertions assume a well-behaved backend. It raises `be_done` only while a command is executing and writes response bytes only during execution. They also assume the host never strobes a read and a write in the same cycle. The stimulus keeps to these rules: the backend model acts only after it has seen `be_start`, and every host access is a single strobe with an idle cycle after it. The completion event is never made to collide with a host status write.

// File: rtl/cfe_pkg.sv
package cfe_pkg;
   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_READY = 3'd1,
      ST_RECV  = 3'd2,
      ST_EXEC  = 3'd3,
      ST_DONE  = 3'd4
   } cfe_state_e;

   localparam int unsigned B_RETRY  = 1;
   localparam int unsigned B_STDONE = 2;
   localparam int unsigned B_EXPECT = 3;
   localparam int unsigned B_DAVAIL = 4;
   localparam int unsigned B_GO     = 5;
   localparam int unsigned B_CMDRDY = 6;
   localparam int unsigned B_VALID  = 7;

   localparam logic [7:0] M_STDONE = 8'h04;
   localparam logic [7:0] M_EXPECT = 8'h08;
   localparam logic [7:0] M_DAVAIL = 8'h10;
   localparam logic [7:0] M_CMDRDY = 8'h40;
   localparam logic [7:0] M_VALID  = 8'h80;
   localparam logic [7:0] CTRL_MASK = 8'h62;
   localparam logic [7:0] NO_DATA  = 8'hFF;
endpackage

// File: rtl/cfe_buffer.sv
module cfe_buffer #(
   parameter int unsigned DEPTH = 256,
   localparam int unsigned AW = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [7:0]    wdata,
   input  logic [AW-1:0] raddr_a,
   output logic [7:0]    rdata_a,
   input  logic [AW-1:0] raddr_b,
   output logic [7:0]    rdata_b
);
   logic [7:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata_a = mem[raddr_a];
   assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/cfe_len_track.sv
module cfe_len_track #(
   parameter int unsigned AW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [7:0]    wdata,
   output logic [31:0]   len_cur,
   output logic [31:0]   len_next
);
   logic [7:0] hdr  [4];
   logic [7:0] nxt  [4];
   logic       hit;
   logic [1:0] idx;

   assign hit = we && (waddr >= AW'(2)) && (waddr <= AW'(5));
   assign idx = 2'(waddr - AW'(2));

   for (genvar g = 0; g < 4; g++) begin : g_hdr
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                        hdr[g] <= 8'h00;
         else if (hit && idx == 2'(g))      hdr[g] <= wdata;
      end
      assign nxt[g] = (hit && idx == 2'(g)) ? wdata : hdr[g];
   end

   assign len_cur  = {hdr[0], hdr[1], hdr[2], hdr[3]};
   assign len_next = {nxt[0], nxt[1], nxt[2], nxt[3]};
endmodule

// File: rtl/cfe_burst.sv
module cfe_burst #(
   parameter int unsigned DEPTH = 256,
   parameter bit SAT_BYTE_READ  = 1'b1,
   localparam int unsigned PW = $clog2(DEPTH) + 1
) (
   input  logic [PW-1:0] ptr,
   input  logic [PW-1:0] rsp_len,
   input  logic          davail,
   input  logic          byte_read,
   output logic [15:0]   burst
);
   logic [PW-1:0] raw;

   assign raw = davail ? (rsp_len - ptr) : (PW'(DEPTH) - ptr);

   if (SAT_BYTE_READ && DEPTH > 255) begin : g_sat
      assign burst = (byte_read && raw > PW'(255)) ? 16'h00FF : 16'(raw);
   end else begin : g_plain
      logic unused_byte;
      assign unused_byte = byte_read;
      assign burst = 16'(raw);
   end
endmodule

// File: rtl/cfe_ctrl.sv
module cfe_ctrl
   import cfe_pkg::*;
#(
   parameter int unsigned DEPTH = 256,
   localparam int unsigned PW = $clog2(DEPTH) + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          host_wr,
   input  logic          host_rd,
   input  logic          host_fifo_sel,
   input  logic          host_active,
   input  logic [7:0]    host_wdata,
   input  logic [31:0]   len_next,
   input  logic [31:0]   len_cur,
   input  logic          be_done,
   input  logic          be_selftest,
   output cfe_state_e    state,
   output logic [PW-1:0] ptr,
   output logic [PW-1:0] rsp_len,
   output logic [7:0]    flags,
   output logic          host_store,
   output logic          be_start,
   output logic [PW-1:0] be_len,
   output logic          be_cancel,
   output logic          evt_cmd_ready
);
   logic          abort_pend;
   logic          sts_wr, fifo_wr, rd_take, room;
   logic [7:0]    ctl, keep, keep_d, wr_flags;
   logic [PW-1:0] wr_ptr, ptr_inc;

   assign sts_wr  = host_wr && host_active && !host_fifo_sel;
   assign fifo_wr = host_wr && host_active && host_fifo_sel &&
                    (state == ST_READY || state == ST_RECV);
   assign room    = ptr < PW'(DEPTH);
   assign host_store = fifo_wr && room &&
                       (state == ST_READY || flags[B_EXPECT]);
   assign rd_take = host_rd && host_active && host_fifo_sel &&
                    state == ST_DONE && flags[B_DAVAIL];
   assign ctl     = host_wdata & CTRL_MASK;
   assign keep    = flags & M_STDONE;
   assign keep_d  = keep | (be_selftest ? M_STDONE : 8'h00);
   assign ptr_inc = ptr + PW'(1);
   assign rsp_len = (len_cur > 32'(DEPTH)) ? PW'(DEPTH) : PW'(len_cur);

   // fill-side flag update for one FIFO byte
   always_comb begin
      wr_flags = (state == ST_READY) ? (keep | M_EXPECT | M_VALID) : flags;
      wr_ptr   = ptr + PW'(host_store);
      if (wr_flags[B_EXPECT] && !room) wr_flags = keep | M_VALID;
      if (wr_ptr > PW'(5) && wr_flags[B_EXPECT]) begin
         wr_flags = (len_next > 32'(wr_ptr)) ? (keep | M_EXPECT | M_VALID)
                                             : (keep | M_VALID);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state         <= ST_IDLE;
         ptr           <= '0;
         flags         <= 8'h00;
         be_start      <= 1'b0;
         be_len        <= '0;
         be_cancel     <= 1'b0;
         evt_cmd_ready <= 1'b0;
         abort_pend    <= 1'b0;
      end else begin
         be_start      <= 1'b0;
         be_cancel     <= 1'b0;
         evt_cmd_ready <= 1'b0;
         if (be_done && state == ST_EXEC) begin
            ptr <= '0;
            if (abort_pend) begin
               state         <= ST_READY;
               flags         <= keep_d | M_CMDRDY;
               evt_cmd_ready <= 1'b1;
               abort_pend    <= 1'b0;
            end else begin
               state <= ST_DONE;
               flags <= keep_d | M_VALID | M_DAVAIL;
            end
         end else if (sts_wr && $onehot(ctl)) begin
            if (ctl[B_CMDRDY]) begin
               unique case (state)
                  ST_IDLE: begin
                     state         <= ST_READY;
                     flags         <= keep | M_CMDRDY;
                     evt_cmd_ready <= 1'b1;
                  end
                  ST_READY: ptr <= '0;
                  ST_RECV: begin
                     state         <= ST_READY;
                     ptr           <= '0;
                     flags         <= keep | M_CMDRDY;
                     evt_cmd_ready <= 1'b1;
                  end
                  ST_EXEC: begin
                     abort_pend <= 1'b1;
                     be_cancel  <= 1'b1;
                  end
                  ST_DONE: begin
                     ptr   <= '0;
                     state <= ST_READY;
                     if (!flags[B_CMDRDY]) begin
                        flags         <= keep | M_CMDRDY;
                        evt_cmd_ready <= 1'b1;
                     end else begin
                        flags <= flags & ~M_DAVAIL;
                     end
                  end
                  default: ;
               endcase
            end else if (ctl[B_GO]) begin
               if (state == ST_RECV && !flags[B_EXPECT]) begin
                  state    <= ST_EXEC;
                  be_start <= 1'b1;
                  be_len   <= ptr;
               end
            end else if (state == ST_DONE) begin
               ptr   <= '0;
               flags <= keep | M_VALID | M_DAVAIL;
            end
         end else if (fifo_wr) begin
            state <= ST_RECV;
            flags <= wr_flags;
            ptr   <= wr_ptr;
         end else if (rd_take) begin
            ptr <= ptr_inc;
            if (ptr_inc >= rsp_len) flags <= keep | M_VALID;
         end
      end
   end

   assert_ptr_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ptr <= PW'(DEPTH));
   assert_expect_in_recv_R4: assert property (@(posedge clk) disable iff (!rst_n)
      flags[B_EXPECT] |-> state == ST_RECV);
   assert_davail_in_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
      flags[B_DAVAIL] |-> state == ST_DONE);
   assert_start_in_exec_R7: assert property (@(posedge clk) disable iff (!rst_n)
      be_start |-> state == ST_EXEC);
   assert_cancel_in_exec_R13: assert property (@(posedge clk) disable iff (!rst_n)
      be_cancel |-> state == ST_EXEC);
   assert_done_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_EXEC && be_done && !abort_pend) |=>
      (state == ST_DONE && ptr == '0 && flags[B_VALID] && flags[B_DAVAIL]));
   assert_selftest_sticky_R14: assert property (@(posedge clk) disable iff (!rst_n)
      flags[B_STDONE] |=> flags[B_STDONE]);
   // input contract: backend completes only an executing command (R8)
   assert_done_only_exec_R8: assert property (@(posedge clk) disable iff (!rst_n)
      be_done |-> state == ST_EXEC);
endmodule

// File: rtl/cmdrsp_fifo_engine.sv
module cmdrsp_fifo_engine
   import cfe_pkg::*;
#(
   parameter int unsigned DEPTH         = 256,
   parameter logic [1:0]  FAMILY        = 2'b10,
   parameter bit          SAT_BYTE_READ = 1'b1,
   localparam int unsigned AW = $clog2(DEPTH),
   localparam int unsigned PW = $clog2(DEPTH) + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          host_wr,
   input  logic          host_rd,
   input  logic          host_fifo_sel,
   input  logic          host_active,
   input  logic          host_byte_rd,
   input  logic [7:0]    host_wdata,
   output logic [31:0]   host_rdata,
   output logic          be_start,
   output logic [PW-1:0] be_len,
   output logic          be_cancel,
   input  logic [AW-1:0] be_raddr,
   output logic [7:0]    be_rdata,
   input  logic          be_we,
   input  logic [AW-1:0] be_waddr,
   input  logic [7:0]    be_wdata,
   input  logic          be_done,
   input  logic          be_selftest,
   output logic          evt_cmd_ready
);
   if (DEPTH < 8 || DEPTH > 4096) begin : g_bad_depth
      $error("cmdrsp_fifo_engine: DEPTH must lie in 8..4096");
   end

   cfe_state_e    state;
   logic [PW-1:0] ptr, rsp_len;
   logic [7:0]    flags, buf_rd, buf_wdata, fifo_byte;
   logic [AW-1:0] buf_waddr;
   logic [31:0]   len_cur, len_next;
   logic [15:0]   burst;
   logic          host_store, buf_we, be_we_ok;

   assign be_we_ok  = be_we && state == ST_EXEC;
   assign buf_we    = host_store || be_we_ok;
   assign buf_waddr = host_store ? ptr[AW-1:0] : be_waddr;
   assign buf_wdata = host_store ? host_wdata : be_wdata;

   cfe_buffer #(.DEPTH(DEPTH)) u_buf (
      .clk     (clk),
      .we      (buf_we),
      .waddr   (buf_waddr),
      .wdata   (buf_wdata),
      .raddr_a (ptr[AW-1:0]),
      .rdata_a (buf_rd),
      .raddr_b (be_raddr),
      .rdata_b (be_rdata)
   );

   cfe_len_track #(.AW(AW)) u_len (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (buf_we),
      .waddr    (buf_waddr),
      .wdata    (buf_wdata),
      .len_cur  (len_cur),
      .len_next (len_next)
   );

   cfe_ctrl #(.DEPTH(DEPTH)) u_ctrl (
      .clk           (clk),
      .rst_n         (rst_n),
      .host_wr       (host_wr),
      .host_rd       (host_rd),
      .host_fifo_sel (host_fifo_sel),
      .host_active   (host_active),
      .host_wdata    (host_wdata),
      .len_next      (len_next),
      .len_cur       (len_cur),
      .be_done       (be_done),
      .be_selftest   (be_selftest),
      .state         (state),
      .ptr           (ptr),
      .rsp_len       (rsp_len),
      .flags         (flags),
      .host_store    (host_store),
      .be_start      (be_start),
      .be_len        (be_len),
      .be_cancel     (be_cancel),
      .evt_cmd_ready (evt_cmd_ready)
   );

   cfe_burst #(.DEPTH(DEPTH), .SAT_BYTE_READ(SAT_BYTE_READ)) u_burst (
      .ptr       (ptr),
      .rsp_len   (rsp_len),
      .davail    (flags[B_DAVAIL]),
      .byte_read (host_byte_rd),
      .burst     (burst)
   );

   assign fifo_byte = (state == ST_DONE && flags[B_DAVAIL]) ? buf_rd : NO_DATA;

   always_comb begin
      if (!host_active)       host_rdata = 32'hFFFF_FFFF;
      else if (host_fifo_sel) host_rdata = {24'h0, fifo_byte};
      else                    host_rdata = {4'h0, FAMILY, 2'b00, burst, flags};
   end
endmodule

// File: tb/cmdrsp_fifo_engine_tb.sv
`timescale 1ns/1ps
module cmdrsp_fifo_engine_tb;
   localparam int DEPTH = 256;
   localparam int AW = 8;
   localparam int PW = 9;

   logic clk = 1'b0, rst_n = 1'b0;
   logic host_wr = 0, host_rd = 0, host_fifo_sel = 0, host_active = 1, host_byte_rd = 0;
   logic [7:0] host_wdata = 0;
   logic [31:0] host_rdata;
   logic be_start, be_cancel, evt_cmd_ready;
   logic [PW-1:0] be_len;
   logic [AW-1:0] be_raddr = 0, be_waddr = 0;
   logic [7:0] be_rdata, be_wdata = 0;
   logic be_we = 0, be_done = 0, be_selftest = 0;

   int n_cmp = 0, n_bad = 0;
   bit finished = 0;
   logic [31:0] q_exp[$];
   string q_tag[$];
   logic [31:0] mon_e;
   string mon_t;

   always #4 clk = ~clk;

   cmdrsp_fifo_engine u_dut (
      .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
      .host_fifo_sel(host_fifo_sel), .host_active(host_active),
      .host_byte_rd(host_byte_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .be_start(be_start), .be_len(be_len), .be_cancel(be_cancel),
      .be_raddr(be_raddr), .be_rdata(be_rdata), .be_we(be_we),
      .be_waddr(be_waddr), .be_wdata(be_wdata), .be_done(be_done),
      .be_selftest(be_selftest), .evt_cmd_ready(evt_cmd_ready));

   function automatic logic [31:0] stw(input logic [7:0] fl, input int b);
      return {4'h0, 2'b10, 2'b00, 16'(b), fl};
   endfunction

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // monitor: compare every read against the scoreboard queue
   always @(negedge clk) begin
      if (host_rd) begin
         if (q_exp.size() == 0) check(1'b0, "scoreboard empty", host_rdata, 32'h0);
         else begin
            mon_e = q_exp.pop_front();
            mon_t = q_tag.pop_front();
            check(host_rdata === mon_e, mon_t, host_rdata, mon_e);
         end
      end
   end

   task automatic wr(input bit sel, input logic [7:0] d);
      @(posedge clk); #1;
      host_wr = 1; host_fifo_sel = sel; host_wdata = d;
      @(posedge clk); #1;
      host_wr = 0;
   endtask

   task automatic rd(input bit sel, input bit bytew, input logic [31:0] exp, input string tag);
      @(posedge clk); #1;
      q_exp.push_back(exp); q_tag.push_back(tag);
      host_rd = 1; host_fifo_sel = sel; host_byte_rd = bytew;
      @(posedge clk); #1;
      host_rd = 0; host_byte_rd = 0;
   endtask

   task automatic be_write(input logic [7:0] a, input logic [7:0] d);
      @(posedge clk); #1;
      be_we = 1; be_waddr = a; be_wdata = d;
      @(posedge clk); #1;
      be_we = 0;
   endtask

   task automatic be_finish(input bit st);
      @(posedge clk); #1;
      be_done = 1; be_selftest = st;
      @(posedge clk); #1;
      be_done = 0; be_selftest = 0;
   endtask

   initial begin
      #(200000 * 8);
      if (!finished) begin
         n_bad++; n_cmp++;
         $display("FAIL watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      logic [7:0] cmd [10];
      logic [7:0] rsp [8];
      cmd = '{8'h80, 8'h01, 8'h00, 8'h00, 8'h00, 8'h0A, 8'h00, 8'h00, 8'h01, 8'h44};
      rsp = '{8'h80, 8'h01, 8'h00, 8'h00, 8'h00, 8'h08, 8'hAA, 8'hBB};
      repeat (3) @(posedge clk);
      #1 rst_n = 1;

      rd(0, 0, stw(8'h00, 256), "R1 reset status");
      rd(0, 1, stw(8'h00, 255), "R10 byte read saturates at reset");
      rd(1, 0, 32'h0000_00FF, "R1 fifo no-data after reset");

      wr(1, 8'h55);
      rd(0, 0, stw(8'h00, 256), "R4 fifo write in idle dropped");
      wr(0, 8'h60);
      rd(0, 0, stw(8'h00, 256), "R2 two control bits ignored");
      host_active = 0;
      wr(0, 8'h40);
      rd(0, 0, 32'hFFFF_FFFF, "R2 non-owner read is all ones");
      host_active = 1;
      rd(0, 0, stw(8'h00, 256), "R2 non-owner status write ignored");

      wr(0, 8'h40);
      check(evt_cmd_ready === 1'b1, "R3 event pulse", 32'(evt_cmd_ready), 32'h1);
      rd(0, 0, stw(8'h40, 256), "R3 idle to ready");

      wr(1, cmd[0]);
      rd(0, 0, stw(8'h88, 255), "R4 first byte enters reception");
      for (int i = 1; i < 6; i++) wr(1, cmd[i]);
      rd(0, 0, stw(8'h88, 250), "R5 expect held below length");
      wr(0, 8'h20);
      check(be_start === 1'b0, "R7 go with expect set ignored", 32'(be_start), 32'h0);
      for (int i = 6; i < 10; i++) wr(1, cmd[i]);
      rd(0, 0, stw(8'h80, 246), "R5 expect cleared at length");

      wr(0, 8'h21);
      check(be_start === 1'b1, "R7 start pulse", 32'(be_start), 32'h1);
      check(be_len === 9'd10, "R7 start length", 32'(be_len), 32'd10);
      be_raddr = 8'd9;
      #1 check(be_rdata === 8'h44, "R7 backend sees command", 32'(be_rdata), 32'h44);
      wr(1, 8'h77);
      rd(0, 0, stw(8'h80, 246), "R4 fifo write in execution dropped");

      for (int i = 0; i < 8; i++) be_write(8'(i), rsp[i]);
      be_finish(1'b1);
      rd(0, 0, stw(8'h94, 8), "R8 completion flags and selftest");
      rd(1, 0, 32'h0000_0080, "R9 response byte 0");
      rd(1, 0, 32'h0000_0001, "R9 response byte 1");
      rd(0, 1, stw(8'h94, 6), "R10 remaining response count");
      wr(0, 8'h02);
      rd(0, 0, stw(8'h94, 8), "R11 retry rewinds");
      for (int i = 0; i < 8; i++) rd(1, 0, {24'h0, rsp[i]}, "R9 response stream");
      rd(0, 0, stw(8'h84, 248), "R9 last byte clears data-available");
      rd(1, 0, 32'h0000_00FF, "R9 read after drain gives no-data");
      wr(1, 8'h12);
      rd(0, 0, stw(8'h84, 248), "R4 fifo write in completion dropped");

      wr(0, 8'h40);
      check(evt_cmd_ready === 1'b1, "R12 event on completion exit", 32'(evt_cmd_ready), 32'h1);
      rd(0, 0, stw(8'h44, 256), "R12 completion to ready, R14 selftest kept");
      wr(0, 8'h40);
      check(evt_cmd_ready === 1'b0, "R12 no event in ready", 32'(evt_cmd_ready), 32'h0);
      rd(0, 0, stw(8'h44, 256), "R12 ready rewind only");

      for (int i = 0; i < 3; i++) wr(1, cmd[i]);
      rd(0, 0, stw(8'h8C, 253), "R13 reception before abort");
      wr(0, 8'h40);
      check(evt_cmd_ready === 1'b1, "R13 reception abort event", 32'(evt_cmd_ready), 32'h1);
      rd(0, 0, stw(8'h44, 256), "R13 reception abort to ready");

      for (int i = 0; i < 10; i++) wr(1, cmd[i]);
      wr(0, 8'h20);
      check(be_start === 1'b1, "R7 second start", 32'(be_start), 32'h1);
      wr(0, 8'h40);
      check(be_cancel === 1'b1, "R13 cancel pulse", 32'(be_cancel), 32'h1);
      rd(0, 0, stw(8'h84, 246), "R13 still executing after cancel");
      be_finish(1'b0);
      check(evt_cmd_ready === 1'b1, "R13 event after aborted execution", 32'(evt_cmd_ready), 32'h1);
      rd(0, 0, stw(8'h44, 256), "R13 aborted execution lands in ready");

      wr(1, 8'h80); wr(1, 8'h01); wr(1, 8'h00); wr(1, 8'h00); wr(1, 8'h10); wr(1, 8'h00);
      for (int i = 6; i < DEPTH; i++) wr(1, 8'(i));
      rd(0, 0, stw(8'h8C, 0), "R6 full buffer still expecting");
      rd(0, 1, stw(8'h8C, 0), "R10 byte read of zero room");
      wr(1, 8'hEE);
      rd(0, 0, stw(8'h84, 0), "R6 overflow write clears expect");

      repeat (2) @(posedge clk);
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule